// File: doc/BRIEF.md
# Shift Register with JK-Controlled Entry Stage

This block is a synchronous shift register. It is `WIDTH` bits wide, with a default of 4. On every rising clock edge it does one of two things. It either shifts every stage one place toward the highest index, or it loads all stages from a parallel word at once. An active-low mode input `loadN` selects between the two.

During a shift, the entry stage (index 0) does not take a plain serial bit. It takes its next value from a pair of inputs: `jIn` and an inverted-K input `kbIn`. Depending on the pair, the entry stage is forced high, forced low, inverted or kept. If the two inputs are wired together, the entry stage behaves as an ordinary D-type serial input. Every stage is visible on `q`, and the last stage also has a complemented output.

An active-low reset `rstN` clears every stage at once, with no clock needed. Reset release passes through a small synchronizer of `SYNC_STAGES` flops. After reset deasserts, the register therefore stays at zero for the first `SYNC_STAGES` rising edges. Inside the block, a control module decodes the mode and the entry-stage action into a strobe struct, and a datapath module holds the stages.

Top module: `jk_shift_reg`

## Requirements
- R1: With `loadN` high, after each rising edge every stage i>0 holds the value stage i-1 had before the edge.
- R2: With `loadN` low, after a rising edge `q` equals the `parIn` value present before the edge, whatever `jIn` and `kbIn` are.
- R3: With `loadN` high, `jIn`=1 with `kbIn`=1 makes stage 0 equal 1, and `jIn`=0 with `kbIn`=0 makes stage 0 equal 0.
- R4: With `loadN` high, `jIn`=1 with `kbIn`=0 inverts stage 0, and `jIn`=0 with `kbIn`=1 keeps stage 0 unchanged.
- R5: While `rstN` is low, `q` is all zeros immediately and stays there whatever the clock, mode and data inputs do.
- R6: `qLastN` is always the inverse of `q[WIDTH-1]`, so it reads 1 during reset.
- R7: After `rstN` rises, the first `SYNC_STAGES` rising edges leave `q` at zero. The edge after those acts normally.
- R8: With `jIn` and `kbIn` driven to the same value d in shift mode, stage 0 becomes d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset; its release is synchronized |
| loadN | input | 1 | Low: parallel load; high: shift toward higher index |
| jIn | input | 1 | J input of the entry stage |
| kbIn | input | 1 | Inverted-K input of the entry stage |
| parIn | input | WIDTH | Parallel load word, bit i goes to stage i |
| q | output | WIDTH | True outputs of all stages, bit i is stage i |
| qLastN | output | 1 | Complement of the last stage |

## Verification
The bench builds the block with `WIDTH`=4 and `SYNC_STAGES`=2. At that width, a four-bit expected word fits in a hand-written vector table. A value loaded into stage 0 also reaches the complemented output within three shifts, so all four entry-stage actions can be seen at the far end. With two synchronizer stages, the held-edge window after reset release is short. It is checked edge by edge, first directly and then again under randomized mode, J, inverted-K and data traffic in which reset strikes at arbitrary points between edges.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  typedef enum logic [1:0] {
    FS_CLEAR  = 2'd0,
    FS_HOLD   = 2'd1,
    FS_TOGGLE = 2'd2,
    FS_SET    = 2'd3
  } first_op_e;

  typedef struct packed {
    logic      doLoad;
    logic      doShift;
    first_op_e firstOp;
  } shreg_strobe_t;

endpackage

// File: rtl/shreg_ctrl.sv
module shreg_ctrl
  import shreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadN,
  input  logic          jIn,
  input  logic          kbIn,
  output shreg_strobe_t strobe,
  output logic          rstInt
);

  logic [SYNC_STAGES-1:0] syncQ;

  // Reset asserts at once and is released through a short flop chain.
  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b0;
        else       syncQ <= 1'b1;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rstInt = syncQ[SYNC_STAGES-1];

  // Decode the mode input and the J / inverted-K pair into strobes.
  always_comb begin
    strobe.doLoad  = !loadN;
    strobe.doShift = loadN;
    unique case ({jIn, kbIn})
      2'b00:   strobe.firstOp = FS_CLEAR;
      2'b01:   strobe.firstOp = FS_HOLD;
      2'b10:   strobe.firstOp = FS_TOGGLE;
      default: strobe.firstOp = FS_SET;
    endcase
  end

endmodule

// File: rtl/shreg_datapath.sv
module shreg_datapath
  import shreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstInt,
  input  shreg_strobe_t    strobe,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] nextQ;
  logic             firstNext;

  always_comb begin
    unique case (strobe.firstOp)
      FS_CLEAR:  firstNext = 1'b0;
      FS_HOLD:   firstNext = q[0];
      FS_TOGGLE: firstNext = ~q[0];
      default:   firstNext = 1'b1;
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_stage
      if (gi == 0) begin : g_entry
        always_comb begin
          if (strobe.doLoad)       nextQ[gi] = parIn[gi];
          else if (strobe.doShift) nextQ[gi] = firstNext;
          else                     nextQ[gi] = q[gi];
        end
      end else begin : g_follow
        always_comb begin
          if (strobe.doLoad)       nextQ[gi] = parIn[gi];
          else if (strobe.doShift) nextQ[gi] = q[gi-1];
          else                     nextQ[gi] = q[gi];
        end
      end
      always_ff @(posedge clk or negedge rstInt) begin
        if (!rstInt) q[gi] <= 1'b0;
        else         q[gi] <= nextQ[gi];
      end
    end
  endgenerate

endmodule

// File: rtl/jk_shift_reg.sv
module jk_shift_reg
  import shreg_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadN,
  input  logic             jIn,
  input  logic             kbIn,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] q,
  output logic             qLastN
);

  shreg_strobe_t strobe;
  logic          rstInt;

  shreg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .loadN  (loadN),
    .jIn    (jIn),
    .kbIn   (kbIn),
    .strobe (strobe),
    .rstInt (rstInt)
  );

  shreg_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstInt (rstInt),
    .strobe (strobe),
    .parIn  (parIn),
    .q      (q)
  );

  assign qLastN = ~q[WIDTH-1];

endmodule

// File: rtl/shreg_checker.sv
module shreg_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             active,
  input logic             loadN,
  input logic             jIn,
  input logic             kbIn,
  input logic [WIDTH-1:0] parIn,
  input logic [WIDTH-1:0] q,
  input logic             qLastN
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |-> (q == '0 && qLastN)); // R5

  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (active && loadN) |=> (q[WIDTH-1:1] == $past(q[WIDTH-2:0]))); // R1

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (active && !loadN) |=> (q == $past(parIn))); // R2

  AST_ENTRY_SET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (active && loadN && (jIn == kbIn)) |=> (q[0] == $past(jIn))); // R3

  AST_ENTRY_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (active && loadN && jIn && !kbIn) |=> (q[0] != $past(q[0]))); // R4

  AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (active && loadN && !jIn && kbIn) |=> $stable(q[0])); // R4

  AST_HOLDOFF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (q == '0)); // R7

endmodule

bind jk_shift_reg shreg_checker #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .active (rstInt),
  .loadN  (loadN),
  .jIn    (jIn),
  .kbIn   (kbIn),
  .parIn  (parIn),
  .q      (q),
  .qLastN (qLastN)
);

// File: tb/test_jk_shift_reg.sv
`timescale 1ns/1ps
module test_jk_shift_reg;

  localparam int W    = 4;
  localparam int SYNC = 2;

  logic         clk = 1'b0;
  logic         rstN;
  logic         loadN;
  logic         jIn;
  logic         kbIn;
  logic [W-1:0] parIn;
  logic [W-1:0] q;
  logic         qLastN;

  int nChecks = 0;
  int nFails  = 0;

  logic [W-1:0] model;
  int           relCnt;

  always #2.5 clk = ~clk;

  jk_shift_reg #(.WIDTH(W), .SYNC_STAGES(SYNC)) i_jk_shift_reg (
    .clk(clk), .rstN(rstN), .loadN(loadN), .jIn(jIn), .kbIn(kbIn),
    .parIn(parIn), .q(q), .qLastN(qLastN)
  );

  // Vector: {loadN, j, kb, par[3:0], expected q[3:0]}, starting from q = 0.
  localparam logic [10:0] VEC [14] = '{
    {1'b0, 1'b0, 1'b0, 4'hA, 4'hA},
    {1'b1, 1'b1, 1'b1, 4'h0, 4'h5},
    {1'b1, 1'b0, 1'b0, 4'h0, 4'hA},
    {1'b1, 1'b1, 1'b0, 4'h0, 4'h5},
    {1'b1, 1'b1, 1'b0, 4'h0, 4'hA},
    {1'b1, 1'b0, 1'b1, 4'h0, 4'h4},
    {1'b0, 1'b0, 1'b0, 4'hF, 4'hF},
    {1'b1, 1'b0, 1'b1, 4'h0, 4'hF},
    {1'b1, 1'b0, 1'b0, 4'h0, 4'hE},
    {1'b1, 1'b1, 1'b1, 4'h0, 4'hD},
    {1'b0, 1'b1, 1'b1, 4'h0, 4'h0},
    {1'b1, 1'b1, 1'b0, 4'h0, 4'h1},
    {1'b0, 1'b0, 1'b0, 4'h6, 4'h6},
    {1'b1, 1'b0, 1'b0, 4'h0, 4'hC}
  };

  task automatic check(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkOut(input string tag, input logic [W-1:0] exp);
    check(tag, q, exp);
    check("R6", {{(W-1){1'b0}}, qLastN}, {{(W-1){1'b0}}, ~exp[W-1]});
  endtask

  // Reference update for one rising edge, using inputs held since the last negedge.
  function automatic logic [W-1:0] refNext(input logic [W-1:0] cur);
    logic e0;
    if (!loadN) return parIn;
    e0 = (jIn & ~cur[0]) | (kbIn & cur[0]);
    return {cur[W-2:0], e0};
  endfunction

  // Called at a negedge: drive, take one edge, sample at the next negedge.
  task automatic step(input logic ld, input logic j, input logic kb,
                      input logic [W-1:0] par);
    loadN = ld; jIn = j; kbIn = kb; parIn = par;
    @(posedge clk);
    if (rstN) begin
      if (relCnt < SYNC) relCnt++;
      else               model = refNext(model);
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    #500000;
    nFails++;
    nChecks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    rstN = 1'b0; loadN = 1'b1; jIn = 1'b0; kbIn = 1'b0; parIn = '0;
    model = '0; relCnt = 0;
    repeat (3) @(negedge clk);
    checkOut("R5", '0);

    // R5: clocked loads during reset have no effect.
    step(1'b0, 1'b1, 1'b1, 4'hF);
    checkOut("R5", '0);

    // R7: release, then two held edges, then the third acts.
    rstN = 1'b1;
    step(1'b0, 1'b0, 1'b0, 4'hF);
    checkOut("R7", '0);
    step(1'b0, 1'b0, 1'b0, 4'hF);
    checkOut("R7", '0);
    step(1'b0, 1'b0, 1'b0, 4'h0);
    checkOut("R7", '0);

    // Table walk.
    for (int i = 0; i < 14; i++) begin
      logic [10:0] v;
      string tag;
      v = VEC[i];
      if (!v[10])          tag = "R2";
      else if (v[9] == v[8]) tag = "R3 R8";
      else                 tag = "R4";
      step(v[10], v[9], v[8], v[7:4]);
      model = v[3:0];
      checkOut(tag, v[3:0]);
    end

    // R1: a single 1 walks to the last stage.
    step(1'b0, 1'b0, 1'b0, 4'h1); model = 4'h1;
    for (int i = 1; i < W; i++) begin
      step(1'b1, 1'b0, 1'b0, 4'h0);
      model = 4'h1 << i;
      checkOut("R1", model);
    end

    // R5: asynchronous reset in the middle of a cycle.
    step(1'b0, 1'b0, 1'b0, 4'hF);
    #1 rstN = 1'b0; model = '0; relCnt = 0;
    #0.5 checkOut("R5", '0);
    @(negedge clk);
    step(1'b0, 1'b1, 1'b1, 4'hF);
    checkOut("R5", '0);
    rstN = 1'b1;

    // Randomized traffic against the reference, with occasional reset.
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 39) == 0) begin
        #1 rstN = 1'b0; model = '0; relCnt = 0;
        #0.5 checkOut("R5", '0);
        @(negedge clk);
        rstN = 1'b1;
      end
      step(1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
           W'($urandom));
      checkOut("R1", model);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule